// File: doc/BRIEF.md
# Raster Position Counter with Vertical-Blank Status

This block keeps the beam position for a video display processor. An 8-bit horizontal slot counter moves on each enabled slot. A 9-bit line counter moves once per line, at a fixed slot partway through the line, and not when the slot counter wraps. That slot depends on which of the two horizontal modes is selected: the wide 40-cell mode or the narrow 32-cell mode.

In the 60 Hz region the line counter skips from line 0xEB to line 0x1E5, so that a frame is 262 lines long. In the 50 Hz region the counter runs through all 512 values. The block decodes a vertical-blank flag from the position. That flag is delayed by two slots after the line change at both ends of the blanking period, and it is forced on while the display is disabled.

The block also counts frames and gives a one-cycle pulse on every line advance. The region bit is sampled only when the line counter wraps to zero, so a frame never mixes the two timings.

Top module: `raster_counter`

## Requirements
- R1: `hCount` is 8 bits. It increments by one, wrapping 0xFF to 0x00, in every clock cycle where `slotEn` is 1, and it holds its value when `slotEn` is 0. The line counter also holds when `slotEn` is 0.
- R2: `vCount` increments in the cycle where `hCount` takes the line-change value. That value is 165 when `wideMode` is 1 and 132 when `wideMode` is 0.
- R3: `vCount` is 9 bits and wraps from 0x1FF to 0x000.
- R4: While the latched region is 60 Hz, an increment that would produce 0xEB loads 0x1E5 instead.
- R5: On the inactive-start line, the vertical-blank flag is 1 when `hCount` is at or above the line-change slot plus 2, or below the line-change slot. On line 0x1FF, the flag is 1 only when `hCount` is at or above the line-change slot and below the line-change slot plus 2.
- R6: On lines above the inactive-start line and below 0x1FF, the vertical-blank flag is 1. On the other lines it is 0 (R5 excepted). `statusWord` carries the flag in bit 3, and all of its other bits are 0.
- R7: While `dispEn` is 0, bit 3 of `statusWord` is 1 at every position.
- R8: `frameCount` increments in the cycle where `vCount` becomes the inactive-start line plus 8.
- R9: The inactive-start line is 0xE0 for the 60 Hz region (latched `palMode` = 0) and 0xF0 for the 50 Hz region (latched `palMode` = 1). `palMode` is latched only when `vCount` wraps to 0. The region after reset is 60 Hz.
- R10: `lineAdvance` is 1 for exactly one clock cycle, which is the cycle in which the new `vCount` value first appears.
- R11: After reset, `hCount`, `vCount`, `frameCount` and `lineAdvance` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slotEn | input | 1 | Advance by one slot this cycle |
| wideMode | input | 1 | 1 selects the 40-cell mode, 0 selects the 32-cell mode |
| palMode | input | 1 | Region request: 1 for 50 Hz, 0 for 60 Hz |
| dispEn | input | 1 | Display enable; 0 forces the blank flag on |
| hCount | output | 8 | Horizontal slot counter |
| vCount | output | 9 | Vertical line counter |
| frameCount | output | 8 | Frame counter |
| statusWord | output | 8 | Status; bit 3 is the vertical-blank flag |
| lineAdvance | output | 1 | One-cycle pulse on each line advance |

## Verification
The assertions check the following on every cycle: the slot step and the hold, the absence of forbidden line values in the 60 Hz region, the single-cycle width of `lineAdvance` together with its tie to each line change, the forcing of the flag by display disable, and the line on which the frame counter moves.

The two-slot offsets of the blanking edges, the exact lines where the flag sets and clears, the effect of a region change at the next frame, and mode switches part way through a line can only be shown by the bench. The bench sweeps a full 60 Hz frame and most of a 50 Hz frame. It compares every output in every cycle against a position model computed arithmetically.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef struct packed {
    logic advH;
    logic advV;
    logic jumpV;
    logic bumpFrame;
    logic latchRegion;
  } rasterStrobes_t;
endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int H_W = 8,
  parameter int V_W = 9,
  parameter int WIDE_LINE_SLOT = 165,
  parameter int NARROW_LINE_SLOT = 132,
  parameter int NTSC_INACT = 'hE0,
  parameter int PAL_INACT = 'hF0,
  parameter int FRAME_OFS = 8,
  parameter int NTSC_JUMP_AT = 'hEB
) (
  input  logic           slotEn,
  input  logic           wideMode,
  input  logic           palLatched,
  input  logic [H_W-1:0] hCount,
  input  logic [V_W-1:0] vCount,
  output rasterStrobes_t strobes,
  output logic [H_W-1:0] lineSlot,
  output logic [V_W-1:0] inactLine
);
  localparam logic [H_W-1:0] WIDE_SLOT   = H_W'(WIDE_LINE_SLOT);
  localparam logic [H_W-1:0] NARROW_SLOT = H_W'(NARROW_LINE_SLOT);
  localparam logic [V_W-1:0] JUMP_AT     = V_W'(NTSC_JUMP_AT);
  localparam logic [V_W-1:0] FRAME_DELTA = V_W'(FRAME_OFS);

  logic [H_W-1:0] hNext;
  logic [V_W-1:0] vInc;
  logic [V_W-1:0] vTarget;

  always_comb begin
    lineSlot  = wideMode ? WIDE_SLOT : NARROW_SLOT;
    inactLine = palLatched ? V_W'(PAL_INACT) : V_W'(NTSC_INACT);
    hNext     = hCount + 1'b1;
    vInc      = vCount + 1'b1;
    strobes.advH        = slotEn;
    strobes.advV        = slotEn && (hNext == lineSlot);
    strobes.jumpV       = strobes.advV && !palLatched && (vInc == JUMP_AT);
    vTarget             = strobes.jumpV ? '1 : vInc;
    strobes.bumpFrame   = strobes.advV && !strobes.jumpV && (vInc == inactLine + FRAME_DELTA);
    strobes.latchRegion = strobes.advV && (vTarget == '0) && !strobes.jumpV;
  end
endmodule

// File: rtl/raster_path.sv
module raster_path
  import raster_pkg::*;
#(
  parameter int H_W = 8,
  parameter int V_W = 9,
  parameter int FRAME_W = 8,
  parameter int NTSC_JUMP_AT = 'hEB,
  parameter int NTSC_JUMP_TO = 'h1E5
) (
  input  logic               clk,
  input  logic               rstN,
  input  rasterStrobes_t     strobes,
  input  logic               palMode,
  output logic [H_W-1:0]     hCount,
  output logic [V_W-1:0]     vCount,
  output logic [FRAME_W-1:0] frameCount,
  output logic               palLatched,
  output logic               lineAdvance
);
  localparam logic [V_W-1:0] JUMP_TO = V_W'(NTSC_JUMP_TO);
  localparam logic [V_W-1:0] JUMP_AT = V_W'(NTSC_JUMP_AT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount      <= '0;
      vCount      <= '0;
      frameCount  <= '0;
      palLatched  <= 1'b0;
      lineAdvance <= 1'b0;
    end else begin
      lineAdvance <= strobes.advV;
      if (strobes.advH) hCount <= hCount + 1'b1;
      if (strobes.advV) vCount <= strobes.jumpV ? JUMP_TO : vCount + 1'b1;
      if (strobes.bumpFrame) frameCount <= frameCount + 1'b1;
      if (strobes.latchRegion) palLatched <= palMode;
    end
  end

  AST_H_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advH |=> hCount == $past(hCount) + 1'b1); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advH |=> $stable(hCount) && $stable(vCount)); // R1
  AST_NTSC_GAP: assert property (@(posedge clk) disable iff (!rstN)
    !palLatched |-> !(vCount >= JUMP_AT && vCount < JUMP_TO)); // R4
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    lineAdvance |=> !lineAdvance); // R10
  AST_PULSE_TIED: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vCount) |-> lineAdvance); // R10
endmodule

// File: rtl/raster_blank.sv
module raster_blank #(
  parameter int H_W = 8,
  parameter int V_W = 9,
  parameter int VB_DELAY = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [H_W-1:0] hCount,
  input  logic [V_W-1:0] vCount,
  input  logic [H_W-1:0] lineSlot,
  input  logic [V_W-1:0] inactLine,
  input  logic           dispEn,
  output logic           vblank
);
  localparam logic [V_W-1:0] LAST_LINE = '1;

  logic [H_W-1:0] blankSlot;
  logic midBlank, enterLine, exitLine;

  always_comb begin
    blankSlot = lineSlot + H_W'(VB_DELAY);
    midBlank  = (vCount > inactLine) && (vCount < LAST_LINE);
    enterLine = (vCount == inactLine) && ((hCount >= blankSlot) || (hCount < lineSlot));
    exitLine  = (vCount == LAST_LINE) && (hCount >= lineSlot) && (hCount < blankSlot);
    vblank    = midBlank || enterLine || exitLine || !dispEn;
  end

  AST_DISP_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    !dispEn |-> vblank); // R7
endmodule

// File: rtl/raster_counter.sv
module raster_counter
  import raster_pkg::*;
#(
  parameter int H_W = 8,
  parameter int V_W = 9,
  parameter int FRAME_W = 8,
  parameter int WIDE_LINE_SLOT = 165,
  parameter int NARROW_LINE_SLOT = 132,
  parameter int VB_DELAY = 2,
  parameter int NTSC_INACT = 'hE0,
  parameter int PAL_INACT = 'hF0,
  parameter int FRAME_OFS = 8,
  parameter int NTSC_JUMP_AT = 'hEB,
  parameter int NTSC_JUMP_TO = 'h1E5,
  parameter int STATUS_W = 8,
  parameter int VB_BIT = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                slotEn,
  input  logic                wideMode,
  input  logic                palMode,
  input  logic                dispEn,
  output logic [H_W-1:0]      hCount,
  output logic [V_W-1:0]      vCount,
  output logic [FRAME_W-1:0]  frameCount,
  output logic [STATUS_W-1:0] statusWord,
  output logic                lineAdvance
);
  rasterStrobes_t strobes;
  logic [H_W-1:0] lineSlot;
  logic [V_W-1:0] inactLine;
  logic           palLatched;
  logic           vblank;

  raster_ctrl #(
    .H_W(H_W), .V_W(V_W), .WIDE_LINE_SLOT(WIDE_LINE_SLOT),
    .NARROW_LINE_SLOT(NARROW_LINE_SLOT), .NTSC_INACT(NTSC_INACT),
    .PAL_INACT(PAL_INACT), .FRAME_OFS(FRAME_OFS), .NTSC_JUMP_AT(NTSC_JUMP_AT)
  ) ctrl_i (
    .slotEn(slotEn), .wideMode(wideMode), .palLatched(palLatched),
    .hCount(hCount), .vCount(vCount), .strobes(strobes),
    .lineSlot(lineSlot), .inactLine(inactLine)
  );

  raster_path #(
    .H_W(H_W), .V_W(V_W), .FRAME_W(FRAME_W),
    .NTSC_JUMP_AT(NTSC_JUMP_AT), .NTSC_JUMP_TO(NTSC_JUMP_TO)
  ) path_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .palMode(palMode),
    .hCount(hCount), .vCount(vCount), .frameCount(frameCount),
    .palLatched(palLatched), .lineAdvance(lineAdvance)
  );

  raster_blank #(.H_W(H_W), .V_W(V_W), .VB_DELAY(VB_DELAY)) blank_i (
    .clk(clk), .rstN(rstN), .hCount(hCount), .vCount(vCount),
    .lineSlot(lineSlot), .inactLine(inactLine), .dispEn(dispEn),
    .vblank(vblank)
  );

  always_comb begin
    statusWord = '0;
    statusWord[VB_BIT] = vblank;
  end

  AST_FRAME_LINE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(frameCount) |-> vCount == inactLine + V_W'(FRAME_OFS)); // R8
endmodule

// File: tb/raster_counter_tb_top.sv
module raster_counter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slotEn = 1'b0, wideMode = 1'b1, palMode = 1'b0, dispEn = 1'b1;
  logic [7:0] hCount;
  logic [8:0] vCount;
  logic [7:0] frameCount;
  logic [7:0] statusWord;
  logic       lineAdvance;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  int mH, mV, mFrame, mPulse;
  bit mPal;

  always #4 clk = ~clk;

  raster_counter dut_i (
    .clk(clk), .rstN(rstN), .slotEn(slotEn), .wideMode(wideMode),
    .palMode(palMode), .dispEn(dispEn), .hCount(hCount), .vCount(vCount),
    .frameCount(frameCount), .statusWord(statusWord), .lineAdvance(lineAdvance)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (v=%0h h=%0h)", tag, act, exp, mV, mH);
    end
  endtask

  function automatic int lineSlotOf(bit wide);
    return wide ? 165 : 132;
  endfunction

  function automatic int inactOf(bit pal);
    return pal ? 'hF0 : 'hE0;
  endfunction

  function automatic int expStatus(bit wide, bit disp);
    int ls = lineSlotOf(wide);
    int ia = inactOf(mPal);
    bit vb;
    vb = (mV > ia && mV < 'h1FF)
      || (mV == ia && (mH >= ls + 2 || mH < ls))
      || (mV == 'h1FF && mH >= ls && mH < ls + 2)
      || !disp;
    return vb ? 8 : 0;
  endfunction

  task automatic modelStep(bit en, bit wide, bit pal);
    int nh, nv;
    mPulse = 0;
    if (en) begin
      nh = (mH + 1) % 256;
      if (nh == lineSlotOf(wide)) begin
        nv = (mV + 1) % 512;
        if (!mPal && nv == 'hEB) nv = 'h1E5;
        if (nv == inactOf(mPal) + 8) mFrame = (mFrame + 1) % 256;
        if (nv == 0) mPal = pal;
        mV = nv;
        mPulse = 1;
      end
      mH = nh;
    end
  endtask

  task automatic compareAll();
    string vTag, sTag;
    if (mPulse && mV == 0) vTag = "R3";
    else if (mPulse && mV == 'h1E5) vTag = "R4";
    else if (mPal) vTag = "R9";
    else vTag = "R2";
    if (!dispEn) sTag = "R7";
    else if (mPal && mV == 'hF0) sTag = "R9";
    else if (mV == inactOf(mPal) || mV == 'h1FF) sTag = "R5";
    else sTag = "R6";
    chk("R1 hCount", int'(hCount), mH);
    chk({vTag, " vCount"}, int'(vCount), mV);
    chk("R8 frameCount", int'(frameCount), mFrame);
    chk({sTag, " statusWord"}, int'(statusWord), expStatus(wideMode, dispEn));
    chk("R10 lineAdvance", int'(lineAdvance), mPulse);
  endtask

  initial begin
    mH = 0; mV = 0; mFrame = 0; mPulse = 0; mPal = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11: reset state
    chk("R11 hCount", int'(hCount), 0);
    chk("R11 vCount", int'(vCount), 0);
    chk("R11 frameCount", int'(frameCount), 0);
    chk("R11 lineAdvance", int'(lineAdvance), 0);
    for (int n = 0; n < 135000; n++) begin
      slotEn   = !(n >= 1000 && n < 3000 && (n % 5) == 3);
      wideMode = !((n >= 20000 && n < 40000) || (n >= 66000 && n < 68500));
      dispEn   = !(n >= 5000 && n < 5600);
      palMode  = (n >= 60000);
      modelStep(slotEn, wideMode, palMode);
      @(negedge clk);
      compareAll();
    end
    // R9: region change must have taken effect and the 50 Hz frame bumped
    chk("R9 region latched frame", int'(frameCount), 2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(190000 * 8);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule